// File: doc/BRIEF.md
# I/O Pin Retention Controller

This block sits between the core-side port registers and the pad ring. It keeps the pad outputs and output enables steady while the chip goes into a low-power stop, and hands the pins back to the core after wake-up. There are two stop flavours. A deep stop powers the core logic down, so the pad values are captured into retention registers on entry. From then on the pads are driven from those registers. A light stop keeps everything powered, so the pads keep following the core registers.

After a deep-stop wake-up the pads stay frozen. A status flag reads 1 to tell software that the wake came from a partial power-down and not from a power-on reset. The pads stay frozen and the flag stays set until software writes a 1 to the release bit. A light-stop wake returns straight to normal operation without any release write.

The status read word has two bits. Bit 0 is the deep-wake flag. Bit 1 is the release bit, and it always reads back as 0. A separate stop-active output tells the power sequencer that a stop is in progress.

Top module: `io_retn_ctrl`

## Requirements
- R1: While rst_n is low and right after it is released, freeze is 0, stop_active is 0, status_rd is 2'b00, and pad_out/pad_oe equal core_out/core_oe.
- R2: In normal operation (not frozen), pad_out and pad_oe equal core_out and core_oe in the same cycle, for any pattern.
- R3: A stop_req pulse with stop_deep=1 in normal operation raises freeze and stop_active on the next clock edge. From that edge on, the pads show the core_out/core_oe values present at that edge.
- R4: While freeze is 1, pad_out and pad_oe do not change, whatever happens on core_out and core_oe.
- R5: A stop_req pulse with stop_deep=0 raises stop_active on the next edge and leaves freeze at 0, so the pads keep following the core values.
- R6: In a light stop, wake lowers stop_active on the next edge, with no release write and with status_rd[0] staying 0. A new stop request is accepted on the cycle right after that.
- R7: In a deep stop, wake lowers stop_active and sets status_rd[0] to 1 on the next edge, while freeze stays 1.
- R8: While waiting for release after a deep wake, ack_wr with ack_wdata=1 clears freeze and status_rd[0] on the next edge. The pads then follow the core values again.
- R9: ack_wr with ack_wdata=0 changes nothing. status_rd[1] (the release bit) always reads 0.
- R10: Taking rst_n low at any time, even while frozen or waiting for release, clears freeze, stop_active and status_rd[0] at once, without waiting for a clock edge.
- R11: Three kinds of stimulus are ignored. A wake in normal operation, a stop_req while a stop or release wait is in progress, and a release write before the deep-stop wake all leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| stop_req | input | 1 | Stop entry strobe, one cycle |
| stop_deep | input | 1 | Stop flavour with the strobe: 1 deep, 0 light |
| wake | input | 1 | Wake event, one cycle |
| ack_wr | input | 1 | Write strobe for the release bit |
| ack_wdata | input | 1 | Value written to the release bit |
| core_out | input | NUM_PINS | Core-side output data |
| core_oe | input | NUM_PINS | Core-side output enables |
| pad_out | output | NUM_PINS | Output data to the pads |
| pad_oe | output | NUM_PINS | Output enables to the pads |
| freeze | output | 1 | Pad latch hold indication |
| stop_active | output | 1 | A stop is in progress |
| status_rd | output | 2 | Bit 0 deep-wake flag, bit 1 release bit (reads 0) |

## Verification
The bench drives changing core_out/core_oe words in every phase and compares every output against a behavioural model on every clock. Changing the core words during a light stop shows that the pads pass the core values through. Changing them during a deep stop and the release wait shows that the pads hold the captured values. A distinctive word is present exactly at the deep-entry edge, which shows whether the capture is taken at that edge or one cycle off. Stray wake, stop and release pulses are placed in each state, and a zero write is placed before the real release, so that the bench can tell which transitions are legal and which stimulus is ignored.

// File: rtl/io_retn_pkg.sv
package io_retn_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DEEP  = 2'd1,
    ST_LIGHT = 2'd2,
    ST_HOLD  = 2'd3
  } retn_state_e;

  localparam int unsigned STAT_W     = 2;
  localparam int unsigned STAT_FLAG  = 0;
  localparam int unsigned STAT_ACK   = 1;

  function automatic logic is_frozen(input retn_state_e s);
    return (s == ST_DEEP) || (s == ST_HOLD);
  endfunction

  function automatic logic is_stopped(input retn_state_e s);
    return (s == ST_DEEP) || (s == ST_LIGHT);
  endfunction

endpackage

// File: rtl/io_retn_fsm.sv
module io_retn_fsm
  import io_retn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic stop_deep,
  input  logic wake,
  input  logic ack_wr,
  input  logic ack_wdata,
  output logic freeze,
  output logic stop_active,
  output logic wake_flag,
  output logic capture_en
);

  retn_state_e state_q, state_d;
  logic        freeze_q, freeze_d;
  logic        stop_q, stop_d;
  logic        flag_q, flag_d;
  logic        flag_en;
  logic        release_hit;
  logic        deep_wake;

  assign release_hit = ack_wr && ack_wdata;
  assign deep_wake   = (state_q == ST_DEEP) && wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req) begin
          state_d = stop_deep ? ST_DEEP : ST_LIGHT;
        end
      end
      ST_DEEP: begin
        if (wake) begin
          state_d = ST_HOLD;
        end
      end
      ST_LIGHT: begin
        if (wake) begin
          state_d = ST_RUN;
        end
      end
      ST_HOLD: begin
        if (release_hit) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag_q;
    if (deep_wake) begin
      flag_en = 1'b1;
      flag_d  = 1'b1;
    end else if ((state_q == ST_HOLD) && release_hit) begin
      flag_en = 1'b1;
      flag_d  = 1'b0;
    end
  end

  assign freeze_d   = is_frozen(state_d);
  assign stop_d     = is_stopped(state_d);
  assign capture_en = (state_q == ST_RUN) && stop_req && stop_deep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      freeze_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      freeze_q <= freeze_d;
      stop_q   <= stop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign freeze      = freeze_q;
  assign stop_active = stop_q;
  assign wake_flag   = flag_q;

endmodule

// File: rtl/io_retn_bank.sv
module io_retn_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_en) begin
      hold_q <= d_in;
    end
  end

  assign q_out = hold_q;

endmodule

// File: rtl/io_retn_padmux.sv
module io_retn_padmux #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                freeze,
  input  logic [NUM_PINS-1:0] live_out,
  input  logic [NUM_PINS-1:0] live_oe,
  input  logic [NUM_PINS-1:0] held_out,
  input  logic [NUM_PINS-1:0] held_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      if (freeze) begin
        pad_out[p] = held_out[p];
        pad_oe[p]  = held_oe[p];
      end else begin
        pad_out[p] = live_out[p];
        pad_oe[p]  = live_oe[p];
      end
    end
  end

endmodule

// File: rtl/io_retn_ctrl.sv
module io_retn_ctrl
  import io_retn_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic                stop_deep,
  input  logic                wake,
  input  logic                ack_wr,
  input  logic                ack_wdata,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                freeze,
  output logic                stop_active,
  output logic [1:0]          status_rd
);

  localparam int unsigned BANK_W = 2 * NUM_PINS;

  logic              cap_en;
  logic              wake_flag;
  logic [BANK_W-1:0] bank_q;

  io_retn_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .stop_deep  (stop_deep),
    .wake       (wake),
    .ack_wr     (ack_wr),
    .ack_wdata  (ack_wdata),
    .freeze     (freeze),
    .stop_active(stop_active),
    .wake_flag  (wake_flag),
    .capture_en (cap_en)
  );

  io_retn_bank #(.WIDTH(BANK_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_en(cap_en),
    .d_in  ({core_oe, core_out}),
    .q_out (bank_q)
  );

  io_retn_padmux #(.NUM_PINS(NUM_PINS)) u_mux (
    .freeze  (freeze),
    .live_out(core_out),
    .live_oe (core_oe),
    .held_out(bank_q[NUM_PINS-1:0]),
    .held_oe (bank_q[BANK_W-1:NUM_PINS]),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  always_comb begin
    status_rd            = '0;
    status_rd[STAT_FLAG] = wake_flag;
    status_rd[STAT_ACK]  = 1'b0;
  end

endmodule

// File: rtl/io_retn_ctrl_chk.sv
module io_retn_ctrl_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stop_req,
  input logic                stop_deep,
  input logic                wake,
  input logic                ack_wr,
  input logic                ack_wdata,
  input logic [NUM_PINS-1:0] core_out,
  input logic [NUM_PINS-1:0] core_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                freeze,
  input logic                stop_active,
  input logic                flag
);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!freeze && !stop_active && !flag); // R10
    end
  end

  AST_RUN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |-> (pad_out == core_out) && (pad_oe == core_oe)); // R2

  AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !stop_active && stop_req && stop_deep)
    |=> freeze && stop_active && (pad_out == $past(core_out)) && (pad_oe == $past(core_oe))); // R3

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && $past(freeze)) |-> $stable(pad_out) && $stable(pad_oe)); // R4

  AST_LIGHT_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && !freeze) |=> !freeze); // R5

  AST_LIGHT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && !freeze && wake) |=> !stop_active && !flag); // R6

  AST_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_active && freeze && wake) |=> freeze && flag && !stop_active); // R7

  AST_FLAG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> freeze); // R7

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !stop_active && ack_wr && ack_wdata) |=> !freeze && !flag); // R8

  AST_ACK_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && ack_wr && !ack_wdata) |=> freeze); // R9

  AST_RUN_WAKE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !stop_active && wake && !stop_req) |=> !freeze && !stop_active && !flag); // R11

endmodule

bind io_retn_ctrl io_retn_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_req   (stop_req),
  .stop_deep  (stop_deep),
  .wake       (wake),
  .ack_wr     (ack_wr),
  .ack_wdata  (ack_wdata),
  .core_out   (core_out),
  .core_oe    (core_oe),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .freeze     (freeze),
  .stop_active(stop_active),
  .flag       (status_rd[0])
);

// File: tb/tb_io_retn_ctrl.sv
module tb_io_retn_ctrl;

  localparam int NP = 8;

  logic          clk;
  logic          rst_n;
  logic          stop_req, stop_deep, wake, ack_wr, ack_wdata;
  logic [NP-1:0] core_out, core_oe;
  logic [NP-1:0] pad_out, pad_oe;
  logic          freeze, stop_active;
  logic [1:0]    status_rd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model: 0 normal, 1 deep stop, 2 light stop, 3 awaiting release
  int            m_st;
  logic          m_flag;
  logic [NP-1:0] m_hout, m_hoe;

  io_retn_ctrl #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_deep(stop_deep),
    .wake(wake), .ack_wr(ack_wr), .ack_wdata(ack_wdata),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .freeze(freeze), .stop_active(stop_active), .status_rd(status_rd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_flag = 1'b0; m_hout = '0; m_hoe = '0;
  endtask

  task automatic compare(input string req);
    logic          e_frz, e_stp;
    logic [NP-1:0] e_po, e_pe;
    e_frz = (m_st == 1) || (m_st == 3);
    e_stp = (m_st == 1) || (m_st == 2);
    e_po  = e_frz ? m_hout : core_out;
    e_pe  = e_frz ? m_hoe  : core_oe;
    chk(req, "freeze", 32'(freeze), 32'(e_frz));
    chk(req, "stop_active", 32'(stop_active), 32'(e_stp));
    chk(req, "status_rd", 32'(status_rd), 32'({1'b0, m_flag}));
    chk(req, "pad_out", 32'(pad_out), 32'(e_po));
    chk(req, "pad_oe", 32'(pad_oe), 32'(e_pe));
  endtask

  // one clock: model follows the inputs at the edge, outputs compared on the falling edge
  task automatic step(input string req);
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      case (m_st)
        0: if (stop_req) begin
             if (stop_deep) begin m_st = 1; m_hout = core_out; m_hoe = core_oe; end
             else m_st = 2;
           end
        1: if (wake) begin m_st = 3; m_flag = 1'b1; end
        2: if (wake) m_st = 0;
        3: if (ack_wr && ack_wdata) begin m_st = 0; m_flag = 1'b0; end
        default: m_st = 0;
      endcase
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle_in();
    stop_req = 0; stop_deep = 0; wake = 0; ack_wr = 0; ack_wdata = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_in(); core_out = 8'h3C; core_oe = 8'hF0;
    model_reset();
    repeat (3) step("R1");
    rst_n = 1;
    step("R1");

    // R2: pass-through with varied patterns
    for (int i = 0; i < 6; i++) begin
      core_out = 8'(8'h11 * i + 8'h07); core_oe = 8'(~(8'h13 * i));
      step("R2");
    end

    // R11: wake and release writes in normal operation are ignored
    wake = 1; step("R11"); wake = 0;
    ack_wr = 1; ack_wdata = 1; step("R11"); idle_in();

    // R3: deep entry captures the value present at the request edge
    core_out = 8'hA5; core_oe = 8'h0F;
    stop_req = 1; stop_deep = 1; step("R3"); idle_in();
    chk("R3", "held pad_out", 32'(pad_out), 32'h A5);
    chk("R3", "held pad_oe", 32'(pad_oe), 32'h0F);

    // R4: core changes while frozen
    for (int i = 0; i < 4; i++) begin
      core_out = 8'(8'h5A ^ (8'h21 * i)); core_oe = 8'(8'hC3 + i);
      step("R4");
      chk("R4", "frozen pad_out", 32'(pad_out), 32'hA5);
    end

    // R11: stop request and release write in deep stop are ignored
    stop_req = 1; stop_deep = 0; step("R11"); idle_in();
    ack_wr = 1; ack_wdata = 1; step("R11"); idle_in();
    chk("R11", "still frozen", 32'(freeze), 32'd1);

    // R7: deep wake sets the flag, pads stay held
    wake = 1; core_out = 8'hFF; step("R7"); idle_in();
    chk("R7", "flag", 32'(status_rd[0]), 32'd1);
    core_out = 8'h00; core_oe = 8'h00; step("R4");

    // R9: zero write does nothing, release bit reads 0
    ack_wr = 1; ack_wdata = 0; step("R9"); idle_in();
    chk("R9", "freeze after zero write", 32'(freeze), 32'd1);
    chk("R9", "release bit reads 0", 32'(status_rd[1]), 32'd0);
    stop_req = 1; stop_deep = 1; step("R11"); idle_in();

    // R8: release
    core_out = 8'h96; core_oe = 8'h69;
    ack_wr = 1; ack_wdata = 1; step("R8"); idle_in();
    chk("R8", "live pad_out", 32'(pad_out), 32'h96);
    chk("R8", "flag cleared", 32'(status_rd[0]), 32'd0);

    // R5 / R6: light stop
    stop_req = 1; stop_deep = 0; step("R5"); idle_in();
    for (int i = 0; i < 3; i++) begin
      core_out = 8'(8'h40 + i * 3); core_oe = 8'(8'h81 << i);
      step("R5");
      chk("R5", "light pad_out follows", 32'(pad_out), 32'(core_out));
    end
    stop_req = 1; stop_deep = 1; step("R11"); idle_in();
    wake = 1; step("R6"); idle_in();
    chk("R6", "stop_active low", 32'(stop_active), 32'd0);
    chk("R6", "flag stays 0", 32'(status_rd[0]), 32'd0);
    core_out = 8'h7E; core_oe = 8'hE7;
    stop_req = 1; stop_deep = 1; step("R6"); idle_in();
    chk("R6", "deep accepted after light", 32'(freeze), 32'd1);

    // R10: reset while awaiting release acts immediately
    wake = 1; step("R7"); idle_in();
    #3 rst_n = 0; #1;
    chk("R10", "freeze async", 32'(freeze), 32'd0);
    chk("R10", "flag async", 32'(status_rd[0]), 32'd0);
    chk("R10", "stop_active async", 32'(stop_active), 32'd0);
    model_reset();
    @(negedge clk);
    step("R10");
    rst_n = 1;
    step("R1");
    core_out = 8'h24; step("R2");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule